// File: doc/BRIEF.md
# Temporally Programmed Address Generator

This block produces the address stream for one port of a small register file of 32 or 64 words. Each port of such a register file has its own copy of the block, and every copy runs on its own. Before a stream starts, a configuration write stores six things:
- the address order;
- a base address;
- a step;
- the number of addresses in one pass;
- a span, used as the buffer length in circular order and as the row width in zig-zag order;
- three delays, and the number of extra passes.

A one-cycle start pulse launches the stream. The block raises a valid strobe in each cycle that carries an address. Between addresses it inserts the programmed wait cycles. It replays the whole pass the programmed number of times and ends with a one-cycle done pulse.

Four orders are available:
- stepped linear;
- wrapped inside a circular buffer;
- bit-reversed index;
- zig-zag, which runs along rows of a given width and reverses direction on every odd row.

The timing is set by three delays, each counted in clock cycles and each allowed to be zero:
- the wait from start to the first address;
- the gap between neighbouring addresses;
- the pause before a pass is replayed.

The configuration is frozen while a stream runs.

Top module: `rf_addr_sequencer`

## Requirements
- R1: After reset, addr_vld, done and busy are all low.
- R2: With cfg_mode = 0 (linear), the k-th address of a pass is (base + k*stride) mod DEPTH.
- R3: With cfg_mode = 1 (circular), the k-th address is (base + ((k*stride) mod span)) mod DEPTH, where stride < span.
- R4: With cfg_mode = 2 (bit-reverse), the k-th address is (base + rev(k)) mod DEPTH. Here rev reverses the low log2(count) bits of k, and count is a power of two.
- R5: With cfg_mode = 3 (zig-zag), let row r = k / span and column c = k mod span. The address is (base + r*span + c) on even rows and (base + r*span + span-1-c) on odd rows, mod DEPTH.
- R6: When start is sampled at clock edge E, the first address is valid in the cycle that follows edge E + init_dly.
- R7: Inside a pass, exactly mid_dly cycles with addr_vld low separate neighbouring addresses. A zero value gives addresses on back-to-back cycles.
- R8: After the last address of a pass that is not the final one, exactly rep_dly idle cycles pass. The next pass then starts again from index 0. There are reps+1 passes in total.
- R9: done is high for exactly one cycle, the cycle right after the final address. busy is low in that cycle.
- R10: A configuration write or a start pulse that arrives while busy is high has no effect on the running stream or on any later stream.
- R11: Every pass issues exactly count addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Stores all cfg_* fields when the block is idle |
| cfg_mode | input | 2 | Order: 0 linear, 1 circular, 2 bit-reverse, 3 zig-zag |
| cfg_base | input | AW | Base address |
| cfg_stride | input | AW | Step for the linear and circular orders |
| cfg_count | input | AW+1 | Addresses per pass, 1..DEPTH |
| cfg_span | input | AW+1 | Circular buffer length or zig-zag row width, at least 1 |
| cfg_init_dly | input | DLY_W | Cycles before the first address |
| cfg_mid_dly | input | DLY_W | Cycles between neighbouring addresses |
| cfg_rep_dly | input | DLY_W | Cycles before a pass is replayed |
| cfg_reps | input | REP_W | Extra passes after the first |
| start | input | 1 | Launch pulse, honoured only while idle |
| addr_vld | output | 1 | An address is present this cycle |
| addr | output | AW | Generated address |
| done | output | 1 | One-cycle pulse after the final address |
| busy | output | 1 | A stream is in progress |

## Verification
The assertions rely on the configuration being legal. The count lies between 1 and DEPTH and the span is at least 1. The stride is smaller than the span whenever the circular order is used, and the count is a power of two whenever the bit-reverse order is used. Out-of-range values would break the index bound and the wrap arithmetic that the checks depend on. Every directed scenario in the bench programs values that respect these limits. Its one illegal-timing stimulus is a configuration write and a start pulse issued in the middle of a running stream, which is exactly the case that must be ignored.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    ORD_LINEAR = 2'd0,
    ORD_CIRC   = 2'd1,
    ORD_BITREV = 2'd2,
    ORD_ZIGZAG = 2'd3
  } order_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_EMIT = 2'd2
  } phase_e;

endpackage

// File: rtl/agu_pacer.sv
module agu_pacer
  import agu_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int REP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [DLY_W-1:0] init_i,
  input  logic [DLY_W-1:0] mid_i,
  input  logic [DLY_W-1:0] rep_i,
  input  logic [REP_W-1:0] reps_i,
  input  logic             last_i,
  output logic             emit_o,
  output logic             clr_o,
  output logic             adv_o,
  output logic             done_o,
  output logic             busy_o
);

  phase_e           ph_q, ph_n;
  logic [DLY_W-1:0] cnt_q, cnt_n;
  logic [REP_W-1:0] pass_q, pass_n;
  logic             done_q, done_n;
  logic             cnt_en, pass_en;

  always_comb begin
    ph_n   = ph_q;
    cnt_n  = cnt_q;
    pass_n = pass_q;
    done_n = 1'b0;
    clr_o  = 1'b0;
    adv_o  = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (go_i) begin
          clr_o  = 1'b1;
          pass_n = '0;
          if (init_i == '0) begin
            ph_n = PH_EMIT;
          end else begin
            ph_n  = PH_WAIT;
            cnt_n = init_i - DLY_W'(1);
          end
        end
      end
      PH_WAIT: begin
        if (cnt_q == '0) ph_n = PH_EMIT;
        else             cnt_n = cnt_q - DLY_W'(1);
      end
      PH_EMIT: begin
        if (!last_i) begin
          adv_o = 1'b1;
          if (mid_i != '0) begin
            ph_n  = PH_WAIT;
            cnt_n = mid_i - DLY_W'(1);
          end
        end else if (pass_q == reps_i) begin
          ph_n   = PH_IDLE;
          done_n = 1'b1;
        end else begin
          pass_n = pass_q + REP_W'(1);
          clr_o  = 1'b1;
          if (rep_i != '0) begin
            ph_n  = PH_WAIT;
            cnt_n = rep_i - DLY_W'(1);
          end
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  assign cnt_en  = (cnt_n != cnt_q);
  assign pass_en = (pass_n != pass_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pass_q <= '0;
    else if (pass_en) pass_q <= pass_n;
  end

  assign emit_o = (ph_q == PH_EMIT);
  assign busy_o = (ph_q != PH_IDLE);
  assign done_o = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(ph_q == PH_EMIT && last_i)); // R9
  AST_ZERO_INIT_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && go_i && init_i == '0) |=> (ph_q == PH_EMIT)); // R6
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_EMIT && !last_i && mid_i == '0) |=> (ph_q == PH_EMIT)); // R7
  AST_GAP_ENTERS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_EMIT && !last_i && mid_i != '0) |=> (ph_q == PH_WAIT)); // R7

endmodule

// File: rtl/agu_walker.sv
module agu_walker
  import agu_pkg::*;
#(
  parameter int AW = 6,
  parameter int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  input  order_e        mode_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] stride_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] span_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic [CW-1:0] idx_o
);

  logic [CW-1:0] idx_q, idx_n;
  logic [AW-1:0] off_q, off_n;
  logic [CW-1:0] col_q, col_n;
  logic [AW-1:0] row_q, row_n;
  logic          odd_q, odd_n;
  logic          step_en;
  logic [CW-1:0] circ_sum;

  // next-state of the walk position
  always_comb begin
    idx_n    = idx_q;
    off_n    = off_q;
    col_n    = col_q;
    row_n    = row_q;
    odd_n    = odd_q;
    circ_sum = {1'b0, off_q} + {1'b0, stride_i};
    if (clr_i) begin
      idx_n = '0;
      off_n = '0;
      col_n = '0;
      row_n = '0;
      odd_n = 1'b0;
    end else if (adv_i) begin
      idx_n = idx_q + CW'(1);
      unique case (mode_i)
        ORD_LINEAR: off_n = off_q + stride_i;
        ORD_CIRC: begin
          if (circ_sum >= span_i) off_n = AW'(circ_sum - span_i);
          else                    off_n = AW'(circ_sum);
        end
        ORD_ZIGZAG: begin
          if (col_q == span_i - CW'(1)) begin
            col_n = '0;
            row_n = row_q + AW'(span_i);
            odd_n = ~odd_q;
          end else begin
            col_n = col_q + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign step_en = clr_i | adv_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      off_q <= '0;
      col_q <= '0;
      row_q <= '0;
      odd_q <= 1'b0;
    end else if (step_en) begin
      idx_q <= idx_n;
      off_q <= off_n;
      col_q <= col_n;
      row_q <= row_n;
      odd_q <= odd_n;
    end
  end

  // bit-reversed index over log2(count) bits
  int            lg;
  logic [AW-1:0] rev;
  always_comb begin
    lg  = 0;
    rev = '0;
    for (int b = 0; b < CW; b++) begin
      if (count_i[b]) lg = b;
    end
    for (int b = 0; b < AW; b++) begin
      if (b < lg) rev[lg-1-b] = idx_q[b];
    end
  end

  logic [CW-1:0] zz_col;
  assign zz_col = odd_q ? (span_i - CW'(1) - col_q) : col_q;

  always_comb begin
    unique case (mode_i)
      ORD_BITREV: addr_o = base_i + rev;
      ORD_ZIGZAG: addr_o = base_i + row_q + AW'(zz_col);
      default:    addr_o = base_i + off_q;
    endcase
  end

  assign last_o = (idx_q == count_i - CW'(1));
  assign idx_o  = idx_q;

  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (idx_q == '0)); // R8
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i) |=> (idx_q == $past(idx_q) + CW'(1))); // R11

endmodule

// File: rtl/rf_addr_sequencer.sv
module rf_addr_sequencer
  import agu_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DLY_W = 8,
  parameter int REP_W = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_mode,
  input  logic [AW-1:0]    cfg_base,
  input  logic [AW-1:0]    cfg_stride,
  input  logic [CW-1:0]    cfg_count,
  input  logic [CW-1:0]    cfg_span,
  input  logic [DLY_W-1:0] cfg_init_dly,
  input  logic [DLY_W-1:0] cfg_mid_dly,
  input  logic [DLY_W-1:0] cfg_rep_dly,
  input  logic [REP_W-1:0] cfg_reps,
  input  logic             start,
  output logic             addr_vld,
  output logic [AW-1:0]    addr,
  output logic             done,
  output logic             busy
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // configuration held for the whole stream
  order_e           mode_q;
  logic [AW-1:0]    base_q, stride_q;
  logic [CW-1:0]    count_q, span_q;
  logic [DLY_W-1:0] init_q, mid_q, rep_q;
  logic [REP_W-1:0] reps_q;
  logic             cfg_en;

  assign cfg_en = cfg_we & ~busy;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q   <= ORD_LINEAR;
      base_q   <= '0;
      stride_q <= '0;
      count_q  <= CW'(1);
      span_q   <= CW'(1);
      init_q   <= '0;
      mid_q    <= '0;
      rep_q    <= '0;
      reps_q   <= '0;
    end else if (cfg_en) begin
      mode_q   <= order_e'(cfg_mode);
      base_q   <= cfg_base;
      stride_q <= cfg_stride;
      count_q  <= cfg_count;
      span_q   <= cfg_span;
      init_q   <= cfg_init_dly;
      mid_q    <= cfg_mid_dly;
      rep_q    <= cfg_rep_dly;
      reps_q   <= cfg_reps;
    end
  end

  logic          clr, adv, last, emit;
  logic [CW-1:0] idx;

  agu_pacer #(
    .DLY_W (DLY_W),
    .REP_W (REP_W)
  ) u_pacer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .go_i   (start),
    .init_i (init_q),
    .mid_i  (mid_q),
    .rep_i  (rep_q),
    .reps_i (reps_q),
    .last_i (last),
    .emit_o (emit),
    .clr_o  (clr),
    .adv_o  (adv),
    .done_o (done),
    .busy_o (busy)
  );

  agu_walker #(
    .AW (AW),
    .CW (CW)
  ) u_walker (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr_i    (clr),
    .adv_i    (adv),
    .mode_i   (mode_q),
    .base_i   (base_q),
    .stride_i (stride_q),
    .count_i  (count_q),
    .span_i   (span_q),
    .addr_o   (addr),
    .last_o   (last),
    .idx_o    (idx)
  );

  assign addr_vld = emit;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && $past(busy)) |-> $stable({mode_q, base_q, stride_q, count_q, span_q, init_q, mid_q, rep_q, reps_q})); // R10
  AST_IDX_IN_PASS: assert property (@(posedge clk) disable iff (!rst_int_n)
    addr_vld |-> (idx < count_q)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (!busy && !addr_vld)); // R9

endmodule

// File: tb/rf_addr_sequencer_bench.sv
module rf_addr_sequencer_bench;

  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int CW    = 7;
  localparam int DLY_W = 8;
  localparam int REP_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [1:0]       cfg_mode;
  logic [AW-1:0]    cfg_base, cfg_stride;
  logic [CW-1:0]    cfg_count, cfg_span;
  logic [DLY_W-1:0] cfg_init_dly, cfg_mid_dly, cfg_rep_dly;
  logic [REP_W-1:0] cfg_reps;
  logic             start;
  logic             addr_vld, done, busy;
  logic [AW-1:0]    addr;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rf_addr_sequencer #(.DEPTH(DEPTH), .DLY_W(DLY_W), .REP_W(REP_W)) u_rf_addr_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_base(cfg_base), .cfg_stride(cfg_stride), .cfg_count(cfg_count),
    .cfg_span(cfg_span), .cfg_init_dly(cfg_init_dly), .cfg_mid_dly(cfg_mid_dly),
    .cfg_rep_dly(cfg_rep_dly), .cfg_reps(cfg_reps), .start(start),
    .addr_vld(addr_vld), .addr(addr), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int exp_addr(input int m, input int base, input int stride,
                                  input int span, input int count, input int k);
    int lg, rv, r, c;
    case (m)
      0: return (base + k * stride) % DEPTH;
      1: return (base + (k * stride) % span) % DEPTH;
      2: begin
        lg = $clog2(count);
        rv = 0;
        for (int b = 0; b < lg; b++) if ((k >> b) & 1) rv |= 1 << (lg - 1 - b);
        return (base + rv) % DEPTH;
      end
      default: begin
        r = k / span;
        c = k % span;
        return (base + r * span + ((r % 2) ? (span - 1 - c) : c)) % DEPTH;
      end
    endcase
  endfunction

  task automatic write_cfg(input int m, input int base, input int stride, input int count,
                           input int span, input int init, input int mid, input int rep, input int reps);
    cfg_mode     = 2'(m);
    cfg_base     = AW'(base);
    cfg_stride   = AW'(stride);
    cfg_count    = CW'(count);
    cfg_span     = CW'(span);
    cfg_init_dly = DLY_W'(init);
    cfg_mid_dly  = DLY_W'(mid);
    cfg_rep_dly  = DLY_W'(rep);
    cfg_reps     = REP_W'(reps);
    cfg_we       = 1'b1;
    @(negedge clk);
    cfg_we       = 1'b0;
  endtask

  // Launch, trace and compare one stream against the requirement formulas.
  task automatic run_case(input int m, input int base, input int stride, input int count,
                          input int span, input int init, input int mid, input int rep,
                          input int reps, input bit do_write, input bit inject);
    int t[256];
    int a[256];
    int nv, done_at, total, p, k, et, last_t;
    string ttag;
    if (do_write) write_cfg(m, base, stride, count, span, init, mid, rep, reps);
    nv = 0;
    done_at = -1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n < 3000; n++) begin
      if (n == 1) chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
      if (addr_vld) begin
        if (nv < 256) begin
          t[nv] = n;
          a[nv] = int'(addr);
        end
        nv++;
      end
      if (done) begin
        done_at = n;
        chk(busy == 1'b0, "R9", "busy with done", int'(busy), 0);
        break;
      end
      if (inject && n == 2) begin
        // R10: a write and a start in mid-stream must be ignored
        cfg_mode = 2'd0; cfg_base = 6'd33; cfg_stride = 6'd1; cfg_count = 7'd2;
        cfg_init_dly = '0; cfg_mid_dly = '0; cfg_rep_dly = '0; cfg_reps = '0;
        cfg_we = 1'b1;
        start  = 1'b1;
      end
      if (inject && n == 3) begin
        cfg_we = 1'b0;
        start  = 1'b0;
      end
      @(negedge clk);
    end
    total = count * (reps + 1);
    chk(nv == total, "R11", "address count", nv, total);
    for (int j = 0; j < total && j < nv && j < 256; j++) begin
      p  = j / count;
      k  = j % count;
      et = init + 1 + p * ((count - 1) * (mid + 1) + rep + 1) + k * (mid + 1);
      ttag = (j == 0) ? "R6" : ((k == 0) ? "R8" : "R7");
      chk(t[j] == et, ttag, "issue cycle", t[j], et);
      chk(a[j] == exp_addr(m, base, stride, span, count, k), inject ? "R10" : mode_tag(m),
          "address", a[j], exp_addr(m, base, stride, span, count, k));
    end
    last_t = init + 1 + reps * ((count - 1) * (mid + 1) + rep + 1) + (count - 1) * (mid + 1);
    chk(done_at == last_t + 1, "R9", "done cycle", done_at, last_t + 1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", int'(done), 0);
    chk(addr_vld == 1'b0, "R9", "quiet after done", int'(addr_vld), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(addr_vld == 1'b0, "R1", "addr_vld in reset", int'(addr_vld), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
  endtask

  task automatic t_linear;
    run_case(0, 5, 3, 8, 1, 0, 0, 0, 0, 1'b1, 1'b0);     // R2 back-to-back, R7
    run_case(0, 60, 7, 10, 1, 0, 2, 0, 0, 1'b1, 1'b0);   // R2 wrap, R7 gap
  endtask

  task automatic t_circular;
    run_case(1, 10, 3, 9, 5, 3, 0, 0, 0, 1'b1, 1'b0);    // R3, R6
  endtask

  task automatic t_bitrev;
    run_case(2, 16, 0, 8, 1, 1, 0, 2, 1, 1'b1, 1'b0);    // R4, R8
  endtask

  task automatic t_zigzag;
    run_case(3, 0, 0, 12, 4, 0, 1, 0, 2, 1'b1, 1'b0);    // R5, R8 zero pause
  endtask

  task automatic t_busy_ignore;
    run_case(0, 2, 5, 4, 1, 2, 3, 1, 1, 1'b1, 1'b1);     // R10 injected
    run_case(0, 2, 5, 4, 1, 2, 3, 1, 1, 1'b0, 1'b0);     // R10 config kept
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; start = 1'b0;
    cfg_mode = '0; cfg_base = '0; cfg_stride = '0; cfg_count = 7'd1; cfg_span = 7'd1;
    cfg_init_dly = '0; cfg_mid_dly = '0; cfg_rep_dly = '0; cfg_reps = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_linear();
    t_circular();
    t_bitrev();
    t_zigzag();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule